// File: doc/BRIEF.md
# Gigabit Transmit Code-Group Sequencer

This block sits between the byte-wide gigabit transmit interface of a MAC and the code-group encoder of the physical coding layer. On each transmit clock it samples the transmit enable, the transmit control qualifier and the eight-bit transmit octet. One clock later it presents a symbolic code-group kind for the encoder, together with the octet that goes with it and a carrier-sense indication.

The sequencer frames each packet. The first enabled octet is replaced by a Start marker. The following enabled octets pass through as Data, or as Error when the control qualifier is high. The first non-enabled cycle becomes a single End marker. Extension codes follow for as long as the MAC requests carrier extension, and one trailing Extension code always closes the frame before Idle resumes. Input combinations outside the permitted set are flagged in a sticky indicator and are sent as Idle.

Top module: `gx_tx_codegroup_seq`

## Requirements
- R1: While reset is high, and on the first output after reset, the output kind is Idle (code 0), the octet is 0, carrier sense is low and the reserved flag is low, whatever the inputs are.
- R2: An input with enable 0 and control 0 and any octet value, or with enable 0, control 1 and octet upper nibble 5h while no frame is running, gives Idle with octet 0 one clock later, and carrier sense stays low.
- R3: The first enabled cycle after an Idle output gives Start (code 1) with octet 0 one clock later, whatever the control qualifier is. The output after a Start is Data, Error or End.
- R4: An enabled cycle with control 0 inside a frame gives Data (code 2) one clock later, carrying that cycle's octet.
- R5: An enabled cycle with control 1 inside a frame gives Error (code 5) one clock later, carrying that cycle's octet.
- R6: The first non-enabled cycle after a frame's enabled cycles gives exactly one End (code 3) with octet 0 one clock later.
- R7: When carrier extension is not requested after a frame, the End is followed by exactly one Extension (code 4) and then by Idle.
- R8: Each carrier-extension cycle (enable 0, control 1, octet upper nibble 5h) after the End cycle gives an Extension one clock later. The first cycle that is not an extension cycle gives one more trailing Extension, and Idle follows it.
- R9: A reserved input (enable 0, control 1, octet upper nibble not 5h) sets the reserved flag one clock later. The flag then stays set until reset. Outside a frame's enabled cycles and End cycle, such an input gives Idle.
- R10: Carrier sense is high exactly when the output kind is not Idle. This covers Start through the last Extension.
- R11: An enabled cycle during the extension tail starts a new frame with Start one clock later, without an intervening Idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; every input and output is registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_ctrl | input | 1 | Control qualifier: error propagation while enabled, extension or reserved while not enabled |
| txd | input | 8 | Transmit octet |
| cg_kind | output | 3 | Code-group kind: 0 Idle, 1 Start, 2 Data, 3 End, 4 Extension, 5 Error |
| cg_octet | output | 8 | Octet for Data and Error kinds, 0 otherwise |
| crs | output | 1 | Carrier sense, high while the output kind is not Idle |
| reserved_seen | output | 1 | Sticky flag for a reserved input combination |

## Verification
The hardest states to reach are the ones inside the extension tail. There, a reserved code, a fresh enable or a plain gap each leaves the tail in a different way. The stimulus reaches them by ending a frame with an extension run and then, in separate frames, following the run with a reserved octet, with an idle gap, and with an immediate new enable just after the End cycle. A zero-length frame and an error-qualified first octet exercise the Start and End markers at their tightest spacing.

// File: rtl/gx_cg_pkg.sv
`timescale 1ns/1ps
package gx_cg_pkg;

  typedef enum logic [2:0] {
    CG_IDLE  = 3'd0,
    CG_START = 3'd1,
    CG_DATA  = 3'd2,
    CG_END   = 3'd3,
    CG_EXT   = 3'd4,
    CG_ERROR = 3'd5
  } cg_kind_e;

  typedef enum logic [2:0] {
    IC_GAP     = 3'd0,
    IC_EXTEND  = 3'd1,
    IC_RESV    = 3'd2,
    IC_DATA    = 3'd3,
    IC_ERRPROP = 3'd4
  } in_class_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FRAME = 2'd1,
    SQ_TAIL  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/gx_tx_classify.sv
`timescale 1ns/1ps
// Decodes enable, control qualifier and the octet's upper field into an input class.
module gx_tx_classify
  import gx_cg_pkg::*;
#(
  parameter int          EXT_W    = 4,
  parameter logic [EXT_W-1:0] EXT_CODE = 4'h5
) (
  input  logic             en,
  input  logic             ctrl,
  input  logic [EXT_W-1:0] d_hi,
  output in_class_e        cls
);

  always_comb begin
    if (en) begin
      cls = ctrl ? IC_ERRPROP : IC_DATA;
    end else if (!ctrl) begin
      cls = IC_GAP;
    end else if (d_hi == EXT_CODE) begin
      cls = IC_EXTEND;
    end else begin
      cls = IC_RESV;
    end
  end

endmodule

// File: rtl/gx_tx_framer.sv
`timescale 1ns/1ps
// Frame state machine: picks the next code-group kind from the input class.
module gx_tx_framer
  import gx_cg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  in_class_e cls,
  output cg_kind_e  kind_nxt,
  output logic      load_octet,
  output logic      resv_hit
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    kind_nxt   = CG_IDLE;
    load_octet = 1'b0;
    resv_hit   = (cls == IC_RESV);
    case (state_q)
      SQ_IDLE: begin
        if (cls == IC_DATA || cls == IC_ERRPROP) begin
          kind_nxt = CG_START;
          state_d  = SQ_FRAME;
        end
      end
      SQ_FRAME: begin
        if (cls == IC_DATA) begin
          kind_nxt   = CG_DATA;
          load_octet = 1'b1;
        end else if (cls == IC_ERRPROP) begin
          kind_nxt   = CG_ERROR;
          load_octet = 1'b1;
        end else begin
          kind_nxt = CG_END;
          state_d  = SQ_TAIL;
        end
      end
      SQ_TAIL: begin
        if (cls == IC_DATA || cls == IC_ERRPROP) begin
          kind_nxt = CG_START;
          state_d  = SQ_FRAME;
        end else if (cls == IC_EXTEND) begin
          kind_nxt = CG_EXT;
        end else if (cls == IC_RESV) begin
          kind_nxt = CG_IDLE;
          state_d  = SQ_IDLE;
        end else begin
          kind_nxt = CG_EXT;
          state_d  = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SQ_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/gx_tx_outreg.sv
`timescale 1ns/1ps
// Output register stage: kind, octet, carrier sense and the sticky reserved flag.
module gx_tx_outreg
  import gx_cg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cg_kind_e          kind_nxt,
  input  logic              load_octet,
  input  logic              resv_hit,
  input  logic [DATA_W-1:0] d,
  output cg_kind_e          kind_q,
  output logic [DATA_W-1:0] octet_q,
  output logic              crs_q,
  output logic              resv_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= CG_IDLE;
      octet_q <= '0;
      crs_q   <= 1'b0;
      resv_q  <= 1'b0;
    end else begin
      kind_q  <= kind_nxt;
      octet_q <= load_octet ? d : '0;
      crs_q   <= (kind_nxt != CG_IDLE);
      resv_q  <= resv_q | resv_hit;
    end
  end

endmodule

// File: rtl/gx_tx_codegroup_seq.sv
`timescale 1ns/1ps
module gx_tx_codegroup_seq
  import gx_cg_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          EXT_W    = 4,
  parameter logic [EXT_W-1:0] EXT_CODE = 4'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              tx_ctrl,
  input  logic [DATA_W-1:0] txd,
  output logic [2:0]        cg_kind,
  output logic [DATA_W-1:0] cg_octet,
  output logic              crs,
  output logic              reserved_seen
);

  localparam int HI_LSB = DATA_W - EXT_W;

  in_class_e cls;
  cg_kind_e  kind_nxt;
  cg_kind_e  kind_q;
  logic      load_octet;
  logic      resv_hit;

  gx_tx_classify #(.EXT_W(EXT_W), .EXT_CODE(EXT_CODE)) u_classify (
    .en   (tx_en),
    .ctrl (tx_ctrl),
    .d_hi (txd[DATA_W-1:HI_LSB]),
    .cls  (cls)
  );

  gx_tx_framer u_framer (
    .clk        (clk),
    .rst        (rst),
    .cls        (cls),
    .kind_nxt   (kind_nxt),
    .load_octet (load_octet),
    .resv_hit   (resv_hit)
  );

  gx_tx_outreg #(.DATA_W(DATA_W)) u_outreg (
    .clk        (clk),
    .rst        (rst),
    .kind_nxt   (kind_nxt),
    .load_octet (load_octet),
    .resv_hit   (resv_hit),
    .d          (txd),
    .kind_q     (kind_q),
    .octet_q    (cg_octet),
    .crs_q      (crs),
    .resv_q     (reserved_seen)
  );

  assign cg_kind = kind_q;

endmodule

// File: rtl/gx_tx_codegroup_seq_chk.sv
`timescale 1ns/1ps
module gx_tx_codegroup_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic              tx_ctrl,
  input logic [DATA_W-1:0] txd,
  input logic [2:0]        cg_kind,
  input logic [DATA_W-1:0] cg_octet,
  input logic              crs,
  input logic              reserved_seen
);

  logic run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) (rst || !run_q) |=> (run_q ? 1'b1 : (cg_kind == 3'd0 && !crs && !reserved_seen))) else $error("AST_RESET_IDLE"); // R1

  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (rst) (run_q && tx_en && !$past(tx_en) && cg_kind == 3'd0) |=> cg_kind == 3'd1) else $error("AST_START_ON_RISE"); // R3

  AST_AFTER_START: assert property (@(posedge clk) disable iff (rst) (cg_kind == 3'd1) |=> (cg_kind == 3'd2 || cg_kind == 3'd5 || cg_kind == 3'd3)) else $error("AST_AFTER_START"); // R3

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst) (run_q && tx_en && !tx_ctrl && cg_kind != 3'd0 && cg_kind != 3'd3 && cg_kind != 3'd4) |=> (cg_kind == 3'd2 && cg_octet == $past(txd))) else $error("AST_DATA_PASS"); // R4

  AST_END_ON_FALL: assert property (@(posedge clk) disable iff (rst) (run_q && !tx_en && $past(tx_en) && $past(run_q)) |=> cg_kind == 3'd3) else $error("AST_END_ON_FALL"); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) $past(reserved_seen) && run_q |-> reserved_seen) else $error("AST_FLAG_STICKY"); // R9

  AST_CRS_KIND: assert property (@(posedge clk) disable iff (rst) crs == (cg_kind != 3'd0)) else $error("AST_CRS_KIND"); // R10

endmodule

bind gx_tx_codegroup_seq gx_tx_codegroup_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tx_en         (tx_en),
  .tx_ctrl       (tx_ctrl),
  .txd           (txd),
  .cg_kind       (cg_kind),
  .cg_octet      (cg_octet),
  .crs           (crs),
  .reserved_seen (reserved_seen)
);

// File: tb/tb_gx_tx_codegroup_seq.sv
`timescale 1ns/1ps
module tb_gx_tx_codegroup_seq;

  localparam logic [2:0] K_IDLE = 3'd0, K_START = 3'd1, K_DATA = 3'd2,
                         K_END = 3'd3, K_EXT = 3'd4, K_ERR = 3'd5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       tx_ctrl = 1'b1;
  logic [7:0] txd = 8'h12;
  logic [2:0] cg_kind;
  logic [7:0] cg_octet;
  logic       crs;
  logic       reserved_seen;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  bit  exp_flag = 1'b0;

  logic [2:0] q_kind[$];
  logic [7:0] q_oct[$];
  logic       q_flag[$];
  string      q_req[$];

  always #2 clk = ~clk;

  gx_tx_codegroup_seq dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_ctrl(tx_ctrl), .txd(txd),
    .cg_kind(cg_kind), .cg_octet(cg_octet), .crs(crs), .reserved_seen(reserved_seen)
  );

  // Driver: one input cycle plus the expected output it must produce one clock later.
  task automatic cyc(input logic en, input logic ctrl, input logic [7:0] d,
                     input logic [2:0] k, input logic [7:0] o, input string req);
    @(negedge clk);
    tx_en = en; tx_ctrl = ctrl; txd = d;
    if (!en && ctrl && d[7:4] != 4'h5) exp_flag = 1'b1;
    q_kind.push_back(k); q_oct.push_back(o); q_flag.push_back(exp_flag); q_req.push_back(req);
  endtask

  // Start, len data octets (error at err_idx, 0 for none), End, then ext_n-1 Extensions.
  task automatic frame(input logic fc, input int len, input int err_idx,
                       input logic [7:0] base, input int ext_n);
    cyc(1'b1, fc, 8'h55, K_START, 8'h00, "R3");
    for (int i = 1; i <= len; i++) begin
      logic [7:0] b;
      b = base + 8'(i * 19);
      if (i == err_idx) cyc(1'b1, 1'b1, b, K_ERR, b, "R5");
      else              cyc(1'b1, 1'b0, b, K_DATA, b, "R4");
    end
    if (ext_n > 0) begin
      cyc(1'b0, 1'b1, 8'h50, K_END, 8'h00, "R6");
      for (int j = 1; j < ext_n; j++) cyc(1'b0, 1'b1, 8'h50 + 8'(j), K_EXT, 8'h00, "R8");
    end else begin
      cyc(1'b0, 1'b0, 8'hC3, K_END, 8'h00, "R6");
    end
  endtask

  // Monitor: compares each output against the queued expectation.
  always @(posedge clk) begin
    #1;
    if (q_kind.size() > 0) begin
      logic [2:0] ek;
      logic [7:0] eo;
      logic       ef;
      string      er;
      ek = q_kind.pop_front(); eo = q_oct.pop_front();
      ef = q_flag.pop_front(); er = q_req.pop_front();
      checks++;
      if (cg_kind !== ek || cg_octet !== eo || crs !== (ek != K_IDLE) || reserved_seen !== ef) begin
        failures++;
        $display("FAIL %s (R10 crs): kind=%0d octet=%h crs=%b flag=%b expected kind=%0d octet=%h crs=%b flag=%b",
                 er, cg_kind, cg_octet, crs, reserved_seen, ek, eo, (ek != K_IDLE), ef);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates a reserved input
    repeat (3) @(negedge clk);
    checks++;
    if (cg_kind !== K_IDLE || cg_octet !== 8'h00 || crs !== 1'b0 || reserved_seen !== 1'b0) begin
      failures++;
      $display("FAIL R1: kind=%0d octet=%h crs=%b flag=%b expected kind=0 octet=00 crs=0 flag=0",
               cg_kind, cg_octet, crs, reserved_seen);
    end
    tx_en = 1'b0; tx_ctrl = 1'b0; txd = 8'h00;
    @(negedge clk);
    rst = 1'b0;

    cyc(1'b0, 1'b0, 8'h00, K_IDLE, 8'h00, "R1");
    // R2: gap octets are ignored; an extension code with no frame is Idle
    cyc(1'b0, 1'b0, 8'hFF, K_IDLE, 8'h00, "R2");
    cyc(1'b0, 1'b0, 8'hA5, K_IDLE, 8'h00, "R2");
    cyc(1'b0, 1'b1, 8'h57, K_IDLE, 8'h00, "R2");

    // R3 with error-qualified first cycle, R4 data, R6 End, R7 single Extension
    frame(1'b1, 3, 0, 8'h10, 0);
    cyc(1'b0, 1'b0, 8'h99, K_EXT, 8'h00, "R7");
    cyc(1'b0, 1'b0, 8'h00, K_IDLE, 8'h00, "R7");

    // R5 error propagation inside a frame
    frame(1'b0, 5, 3, 8'h40, 0);
    cyc(1'b0, 1'b0, 8'h00, K_EXT, 8'h00, "R7");
    cyc(1'b0, 1'b0, 8'h00, K_IDLE, 8'h00, "R7");

    // R9 reserved outside a frame: Idle, flag set and held
    cyc(1'b0, 1'b1, 8'h23, K_IDLE, 8'h00, "R9");
    cyc(1'b0, 1'b0, 8'h00, K_IDLE, 8'h00, "R9");

    // R8 extension run of 3 after the End, trailing Extension, Idle
    frame(1'b0, 4, 0, 8'h80, 3);
    cyc(1'b0, 1'b0, 8'h00, K_EXT, 8'h00, "R8");
    cyc(1'b0, 1'b0, 8'h00, K_IDLE, 8'h00, "R8");

    // R9 reserved inside the extension tail ends it with Idle
    frame(1'b0, 2, 0, 8'hC0, 2);
    cyc(1'b0, 1'b1, 8'h7A, K_IDLE, 8'h00, "R9");
    cyc(1'b0, 1'b0, 8'h00, K_IDLE, 8'h00, "R9");

    // R11 new enable right after the End cycle
    frame(1'b0, 2, 0, 8'h01, 0);
    frame(1'b0, 1, 0, 8'h33, 0);
    cyc(1'b0, 1'b0, 8'h00, K_EXT, 8'h00, "R11");
    // R11 new enable during an extension run
    frame(1'b0, 1, 0, 8'h21, 2);
    frame(1'b0, 2, 2, 8'h61, 0);
    cyc(1'b0, 1'b0, 8'h00, K_EXT, 8'h00, "R11");
    cyc(1'b0, 1'b0, 8'h00, K_IDLE, 8'h00, "R11");

    // R3/R6 zero-length frame: Start then End
    frame(1'b0, 0, 0, 8'h00, 0);
    cyc(1'b0, 1'b0, 8'h00, K_EXT, 8'h00, "R7");
    cyc(1'b0, 1'b0, 8'h00, K_IDLE, 8'h00, "R2");

    repeat (3) @(negedge clk);
    checks++;
    if (q_kind.size() != 0) begin
      failures++;
      $display("FAIL R10: pending=%0d expected=0", q_kind.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule